// File: doc/BRIEF.md
# Carry-Skip Adder with Four-Bit Groups

This block adds two 16-bit operands and a carry input. The word is cut into four groups of four bits: bits 0-3, 4-7, 8-11 and 12-15. Inside each group, every bit first forms a propagate term (a XOR b) and a generate term (a AND b). The carry then ripples through the group's four bits, and each sum bit is formed last from its propagate term and the carry arriving at that bit.

Each group also ANDs its four propagate terms into a skip condition. When every bit of a group propagates, a multiplexer at the group's carry output hands the group's incoming carry straight to the next group, without waiting for the ripple through the four bits. Otherwise, the group's own ripple chain produces the outgoing carry. That chain either kills or generates the carry somewhere inside the group. The lowest group takes the external carry input, and the highest group's outgoing carry becomes the adder's carry output.

A parameter selects whether the result passes through an output register. The default registers it, with an asynchronous active-low reset, which gives timing closure one clean cycle around the carry path.

Top module: `cbypass_adder16`

## Requirements
- R1: With the output register enabled, `{cout, sum}` equals `a + b + cin` of the operands sampled at the previous rising clock edge, for every input combination.
- R2: While `rst_n` is low, `sum` is 0 and `cout` is 0, and both clear asynchronously when `rst_n` falls.
- R3: Each sum bit is the XOR of that bit's propagate term (`a ^ b`) and the carry entering that bit, so operands with no generating bit (for example 16'h5555 + 16'hAAAA) give a sum equal to `a ^ b` when `cin` is 0.
- R4: When all four bits of a group propagate, the carry leaving that group equals the carry entering it.
- R5: When a group does not fully propagate, its outgoing carry comes from its ripple chain: a generating top bit of the group (bit 3, 7, 11 or 15, with both operand bits 1) forces it to 1, and a killing top bit (both operand bits 0) forces it to 0.
- R6: The lowest group receives `cin`, and each group's outgoing carry is the next group's incoming carry, so a carry can cross several groups (for example 16'h00FF + 16'h0001 = 16'h0100).
- R7: `cout` is the carry leaving the group over bits 12-15.
- R8: When every bit propagates (`a ^ b` = 16'hFFFF), the input carry skips all four groups: the sum is 16'hFFFF and `cout` is 0 when `cin` is 0, and the sum is 0 and `cout` is 1 when `cin` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits, registered by default |
| cout | output | 1 | Carry out of bit 15, registered by default |

## Verification
A wrong skip decision, or a wrong ripple carry inside a group, does not stay inside the block. It shows up as an error in the sum of the next group, or in `cout` if the top group is at fault. With the default register, the error appears on the first clock edge after the operands are applied. The bugs that are hardest to see are those that appear only for particular operands: a skip multiplexer that selects the wrong source is invisible whenever its two inputs agree. For that reason, the stimulus sets whole groups to propagate with each carry-in value, places a generating or killing bit at group boundaries, and runs a long random sweep.

// File: rtl/cbypass_adder16.sv
module cbypass_adder16 #(
  parameter int WIDTH   = 16,
  parameter int GROUP   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] prop, gen, sum_d;
  logic [NGRP:0]    grp_carry;
  logic [NGRP-1:0]  grp_bypass;

  assign prop         = a ^ b;
  assign gen          = a & b;
  assign grp_carry[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    logic [GROUP:0] rc;
    assign rc[0] = grp_carry[gi];
    for (genvar bi = 0; bi < GROUP; bi++) begin : g_bit
      localparam int K = gi * GROUP + bi;
      assign rc[bi+1]  = gen[K] | (prop[K] & rc[bi]);
      assign sum_d[K]  = prop[K] ^ rc[bi];
    end
    assign grp_bypass[gi]   = &prop[gi*GROUP +: GROUP];
    assign grp_carry[gi+1]  = grp_bypass[gi] ? grp_carry[gi] : rc[GROUP];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_d;
        cout <= grp_carry[NGRP];
      end
    end
  end else begin : g_comb
    assign sum  = sum_d;
    assign cout = grp_carry[NGRP];
  end
endmodule

// File: rtl/cbypass_adder16_chk.sv
module cbypass_adder16_chk #(
  parameter int WIDTH   = 16,
  parameter int GROUP   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [WIDTH-1:0]       a,
  input logic [WIDTH-1:0]       b,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic [WIDTH/GROUP:0]   gc,
  input logic [WIDTH/GROUP-1:0] gbp
);
  localparam int NGRP = WIDTH / GROUP;

  if (REG_OUT) begin : g_seq
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)}))); // R1
    AST_COUT_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cout == $past(gc[NGRP]))); // R7
  end

  AST_CHAIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    gc[0] == cin); // R6

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    localparam int TOP = gi * GROUP + GROUP - 1;
    AST_SKIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      gbp[gi] |-> (gc[gi+1] == gc[gi])); // R4
    AST_TOP_GENERATE: assert property (@(posedge clk) disable iff (!rst_n)
      (a[TOP] & b[TOP]) |-> gc[gi+1]); // R5
    AST_TOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!a[TOP] & !b[TOP]) |-> !gc[gi+1]); // R5
  end
endmodule

bind cbypass_adder16 cbypass_adder16_chk #(
  .WIDTH(WIDTH), .GROUP(GROUP), .REG_OUT(REG_OUT)
) chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
  .sum(sum), .cout(cout), .gc(grp_carry), .gbp(grp_bypass)
);

// File: tb/cbypass_adder16_test.sv
module cbypass_adder16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [16:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  cbypass_adder16 uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic drive(input logic [15:0] va, input logic [15:0] vb, input logic vc, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    a = va; b = vb; cin = vc;
    it.exp = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({cout, sum} !== it.exp) begin
        errors++;
        $display("FAIL %s: got cout=%b sum=%h, expected cout=%b sum=%h",
                 it.tag, cout, sum, it.exp[16], it.exp[15:0]);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (sum !== 16'h0 || cout !== 1'b0) begin
      errors++;
      $display("FAIL %s: got cout=%b sum=%h, expected cout=0 sum=0000", tag, cout, sum);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R2 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
    drive(16'h0000, 16'h0000, 1'b1, "R6 cin into bit 0");
    drive(16'h5555, 16'hAAAA, 1'b0, "R3 no generate");
    drive(16'h1234, 16'h4321, 1'b0, "R3 mixed");
    drive(16'hFFFF, 16'h0000, 1'b1, "R8 all skip cin=1");
    drive(16'h0F0F, 16'hF0F0, 1'b1, "R8 all skip split operands");
    drive(16'hFFFF, 16'h0000, 1'b0, "R8 all skip cin=0");
    drive(16'h000F, 16'h0000, 1'b1, "R4 group0 skip");
    drive(16'h0F00, 16'h00F0, 1'b1, "R4 groups 0 ripple 1-2 skip");
    drive(16'h00FF, 16'h0001, 1'b0, "R6 carry across groups");
    drive(16'h0080, 16'h0080, 1'b0, "R5 generate at bit 7");
    drive(16'h0007, 16'h0001, 1'b1, "R5 kill at bit 3");
    drive(16'h8000, 16'h8000, 1'b0, "R7 top generate");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R7 max operands");
    drive(16'hF000, 16'h0FFF, 1'b1, "R7 skip into cout");
    for (int i = 0; i < 3000; i++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    drive(16'h1111, 16'h2222, 1'b0, "R1 before reset");
    @(negedge clk);
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check_reset("R2 asynchronous clear");
    @(negedge clk);
    #2;
    rst_n = 1'b1;
    drive(16'hABCD, 16'h5433, 1'b0, "R1 after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule